// File: doc/BRIEF.md
# USB Device Suspend Controller

This block watches the sampled line state of a full-speed USB device port and tells firmware when the bus has gone quiet long enough to count as a suspend request. Entering suspend does not happen on its own. Firmware must complete a handshake: it takes the status interrupt, reads the live bus bit to confirm the bus is still quiet, clears the clock-run control, and then sets and clears the go-suspend control. The falling edge of that control starts a fixed hardware delay. When the delay ends, the suspend output is raised and the clock-gate enable is dropped.

A small register port with three registers holds the sticky event bit, its interrupt enable, the live bus-status bit, the clock-run control and the go-suspend control. Both timing intervals are parameters counted in sampling-clock cycles. `IDLE_CYC` is the quiet time, nominally 3 ms. `DELAY_CYC` is the entry delay, nominally 2 ms.

The controller runs as a five-state machine:
- AWAKE goes to DETECTED on the idle-detect event.
- DETECTED goes to ARMED when go-suspend is written from 0 to 1.
- ARMED goes to DELAY when go-suspend is written from 1 to 0 and the written clock-run bit is 0. The same falling write with clock-run 1 goes back to DETECTED (rejected).
- DELAY goes to SUSPENDED after `DELAY_CYC` cycles.
- From DETECTED, ARMED, DELAY or SUSPENDED, any non-idle sample returns the machine to AWAKE. These transitions are the abort, cancel and wake paths.

Top module: `usb_susp_ctrl`

## Requirements
- R1: The bus-status bit (address 0, bit 1) reads 1 only after `IDLE_CYC+1` consecutive idle samples of `line_idle`. After exactly `IDLE_CYC` idle samples it still reads 0.
- R2: A single non-idle sample clears the bus-status bit at that clock edge and restarts the idle count from zero.
- R3: The sample that sets the bus-status bit also sets the sticky event bit (address 0, bit 0). Writing 1 to that bit clears it. Writing 0 to it has no effect, and reading it has no effect. A detection in the same cycle as a clearing write wins.
- R4: `irq` equals the event bit ANDed with the interrupt enable (address 1, bit 0).
- R5: The control register (address 2) holds clock-run in bit 0, which resets to 1, and go-suspend in bit 1, which resets to 0. In DETECTED, a write that changes go-suspend from 0 to 1 moves the block to ARMED.
- R6: In ARMED, a write that changes go-suspend from 1 to 0 while writing clock-run as 0 starts the delay. If clock-run is written as 1, the block returns to DETECTED and never suspends.
- R7: `susp_out` rises and `clk_en` falls exactly `DELAY_CYC` clock edges after the edge that starts the delay.
- R8: A non-idle sample during the delay cancels it, and `susp_out` stays 0.
- R9: A non-idle sample while suspended clears `susp_out`, sets `clk_en` and sets the clock-run bit to 1, all at that edge.
- R10: Go-suspend writes made in AWAKE do not change `susp_out`.
- R11: After reset, all register reads are 0 except clock-run, which reads 1. `irq` and `susp_out` are 0 and `clk_en` is 1.
- R12: A non-idle sample in DETECTED or ARMED aborts entry, so a following falling go-suspend write does not start the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_idle | input | 1 | 1 when the sampled bus line state is idle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 status, 1 enable, 2 control) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq | output | 1 | Suspend-event interrupt |
| susp_out | output | 1 | Suspend indication |
| clk_en | output | 1 | Clock-gate enable, 0 while suspended |

## Verification
The bench goes after the off-by-one in the idle threshold: a design that fires at `IDLE_CYC` samples, or one that misses a single-cycle line glitch, shows a wrong bus-status read at the boundary sample. It drives the go-suspend handshake with clock-run still set, aborts it from ARMED, and cancels it in the middle of the delay. A design that trusts any falling edge would raise `susp_out` in each of those cases. It times the delay edge by edge and collides a clearing write with the detecting sample, which exposes a design where clear wins over set. A cycle model runs alongside random idle runs and writes, and catches any state that drifts from the requirements.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE     = 3'd0,
        ST_DETECTED  = 3'd1,
        ST_ARMED     = 3'd2,
        ST_DELAY     = 3'd3,
        ST_SUSPENDED = 3'd4
    } susp_state_t;

    localparam int unsigned REG_STAT     = 0;
    localparam int unsigned REG_IEN      = 1;
    localparam int unsigned REG_CTRL     = 2;

    localparam int unsigned STAT_EVT_BIT = 0;
    localparam int unsigned STAT_BUS_BIT = 1;
    localparam int unsigned IEN_EVT_BIT  = 0;
    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_GO_BIT  = 1;

endpackage

// File: rtl/usb_susp_idle_timer.sv
module usb_susp_idle_timer #(
    parameter int unsigned IDLE_CYC = 36000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_idle,
    output logic bus_idle,
    output logic det_rise
);
    localparam int unsigned CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

    logic [CW-1:0] cnt_q;

    // Detection fires on the sample after LIMIT idle samples have been counted.
    assign det_rise = line_idle && (cnt_q == LIMIT) && !bus_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            bus_idle <= 1'b0;
        end else if (!line_idle) begin
            cnt_q    <= '0;
            bus_idle <= 1'b0;
        end else if (cnt_q != LIMIT) begin
            cnt_q    <= cnt_q + 1'b1;
        end else if (!bus_idle) begin
            bus_idle <= 1'b1;
        end
    end

    assert_flag_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_idle |=> !bus_idle);

    assert_rise_needs_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_idle) |-> $past(line_idle));

endmodule

// File: rtl/usb_susp_regs.sv
module usb_susp_regs
    import usb_susp_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              det_rise,
    input  logic              bus_idle,
    input  logic              wake,
    output logic              irq,
    output logic              go_rise,
    output logic              go_fall,
    output logic              run_wr
);
    logic evt_q;
    logic ie_q;
    logic run_q;
    logic go_q;

    logic sel_stat;
    logic sel_ien;
    logic sel_ctrl;
    logic clr_req;
    logic unused_wdata;

    assign sel_stat = wr_en && (addr == ADDR_W'(REG_STAT));
    assign sel_ien  = wr_en && (addr == ADDR_W'(REG_IEN));
    assign sel_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));
    assign clr_req  = sel_stat && wdata[STAT_EVT_BIT];

    assign go_rise  = sel_ctrl && !go_q &&  wdata[CTRL_GO_BIT];
    assign go_fall  = sel_ctrl &&  go_q && !wdata[CTRL_GO_BIT];
    assign run_wr   = wdata[CTRL_RUN_BIT];
    assign irq      = evt_q && ie_q;
    assign unused_wdata = ^wdata;

    // Sticky event: detection has priority over the write-one-to-clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else if (det_rise) begin
            evt_q <= 1'b1;
        end else if (clr_req) begin
            evt_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (sel_ien) begin
            ie_q <= wdata[IEN_EVT_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b1;
            go_q  <= 1'b0;
        end else begin
            if (wake) begin
                run_q <= 1'b1;
            end else if (sel_ctrl) begin
                run_q <= wdata[CTRL_RUN_BIT];
            end
            if (sel_ctrl) begin
                go_q <= wdata[CTRL_GO_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(REG_STAT): begin
                rdata[STAT_EVT_BIT] = evt_q;
                rdata[STAT_BUS_BIT] = bus_idle;
            end
            ADDR_W'(REG_IEN): begin
                rdata[IEN_EVT_BIT] = ie_q;
            end
            ADDR_W'(REG_CTRL): begin
                rdata[CTRL_RUN_BIT] = run_q;
                rdata[CTRL_GO_BIT]  = go_q;
            end
            default: rdata = '0;
        endcase
    end

    assert_evt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && !clr_req) |=> evt_q);

    assert_evt_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        det_rise |=> evt_q);

    assert_wake_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> run_q);

endmodule

// File: rtl/usb_susp_fsm.sv
module usb_susp_fsm
    import usb_susp_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 24000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_idle,
    input  logic det_rise,
    input  logic go_rise,
    input  logic go_fall,
    input  logic run_wr,
    output logic wake,
    output logic susp_out,
    output logic clk_en
);
    localparam int unsigned DW = $clog2(DELAY_CYC + 1);
    localparam logic [DW-1:0] LAST = DW'(DELAY_CYC - 1);
    localparam logic [DW-1:0] FULL = DW'(DELAY_CYC);

    susp_state_t state_q;
    susp_state_t state_d;
    logic [DW-1:0] dcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_AWAKE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt_q <= '0;
        end else if (state_q == ST_DELAY && line_idle) begin
            dcnt_q <= dcnt_q + 1'b1;
        end else begin
            dcnt_q <= '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE: begin
                if (det_rise) state_d = ST_DETECTED;
            end
            ST_DETECTED: begin
                if (!line_idle)   state_d = ST_AWAKE;
                else if (go_rise) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!line_idle)   state_d = ST_AWAKE;
                else if (go_fall) state_d = run_wr ? ST_DETECTED : ST_DELAY;
            end
            ST_DELAY: begin
                if (!line_idle)          state_d = ST_AWAKE;
                else if (dcnt_q == LAST) state_d = ST_SUSPENDED;
            end
            ST_SUSPENDED: begin
                if (!line_idle) state_d = ST_AWAKE;
            end
            default: state_d = ST_AWAKE;
        endcase
    end

    always_comb begin
        wake     = (state_q == ST_SUSPENDED) && !line_idle;
        susp_out = (state_q == ST_SUSPENDED);
        clk_en   = (state_q != ST_SUSPENDED);
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY) |-> (dcnt_q < FULL));

    assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY && !line_idle) |=> (state_q == ST_AWAKE));

    assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSPENDED && !line_idle) |=> !susp_out);

    assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && line_idle && go_fall && run_wr) |=> (state_q == ST_DETECTED));

    assert_detect_awake_R12: assert property (@(posedge clk) disable iff (!rst_n)
        det_rise |-> (state_q == ST_AWAKE));

endmodule

// File: rtl/usb_susp_ctrl.sv
module usb_susp_ctrl #(
    parameter int unsigned IDLE_CYC  = 36000,
    parameter int unsigned DELAY_CYC = 24000,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_idle,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              susp_out,
    output logic              clk_en
);
    logic bus_idle;
    logic det_rise;
    logic go_rise;
    logic go_fall;
    logic run_wr;
    logic wake;

    usb_susp_idle_timer #(
        .IDLE_CYC (IDLE_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_idle (line_idle),
        .bus_idle  (bus_idle),
        .det_rise  (det_rise)
    );

    usb_susp_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .det_rise (det_rise),
        .bus_idle (bus_idle),
        .wake     (wake),
        .irq      (irq),
        .go_rise  (go_rise),
        .go_fall  (go_fall),
        .run_wr   (run_wr)
    );

    usb_susp_fsm #(
        .DELAY_CYC (DELAY_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_idle (line_idle),
        .det_rise  (det_rise),
        .go_rise   (go_rise),
        .go_fall   (go_fall),
        .run_wr    (run_wr),
        .wake      (wake),
        .susp_out  (susp_out),
        .clk_en    (clk_en)
    );

endmodule

// File: tb/test_usb_susp_ctrl.sv
module test_usb_susp_ctrl;
    localparam int IDLE_T = 20;
    localparam int DLY_T  = 12;
    localparam int S_AW = 0, S_DT = 1, S_AR = 2, S_DL = 3, S_SU = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_idle = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq, susp_out, clk_en;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit done = 1'b0;
    bit run_chk = 1'b0;

    // bench reference model state
    int m_cnt, m_st, m_dcnt;
    bit m_flag, m_evt, m_ie, m_run, m_go;

    always #5 clk = ~clk;

    usb_susp_ctrl #(.IDLE_CYC(IDLE_T), .DELAY_CYC(DLY_T)) i_usb_susp_ctrl (
        .clk(clk), .rst_n(rst_n), .line_idle(line_idle), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .susp_out(susp_out), .clk_en(clk_en));

    function automatic int exp_rdata(input int a);
        case (a)
            0: return {30'd0, m_flag, m_evt};
            1: return {31'd0, m_ie};
            2: return {30'd0, m_go, m_run};
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        bit li, w0, w1, w2, rise, grise, gfall, wake;
        int nst, ndc;
        if (!rst_n) begin
            m_cnt = 0; m_flag = 0; m_evt = 0; m_ie = 0; m_run = 1; m_go = 0;
            m_st = S_AW; m_dcnt = 0;
        end else begin
            li = line_idle;
            w0 = reg_wr && reg_addr == 2'd0;
            w1 = reg_wr && reg_addr == 2'd1;
            w2 = reg_wr && reg_addr == 2'd2;
            rise  = li && m_cnt == IDLE_T && !m_flag;
            grise = w2 && !m_go && reg_wdata[1];
            gfall = w2 && m_go && !reg_wdata[1];
            wake  = m_st == S_SU && !li;
            nst = m_st;
            case (m_st)
                S_AW: if (rise) nst = S_DT;
                S_DT: if (!li) nst = S_AW; else if (grise) nst = S_AR;
                S_AR: if (!li) nst = S_AW; else if (gfall) nst = reg_wdata[0] ? S_DT : S_DL;
                S_DL: if (!li) nst = S_AW; else if (m_dcnt == DLY_T - 1) nst = S_SU;
                default: if (!li) nst = S_AW;
            endcase
            ndc = (m_st == S_DL && li) ? m_dcnt + 1 : 0;
            if (!li) begin m_cnt = 0; m_flag = 0; end
            else if (m_cnt != IDLE_T) m_cnt = m_cnt + 1;
            else if (!m_flag) m_flag = 1;
            if (rise) m_evt = 1; else if (w0 && reg_wdata[0]) m_evt = 0;
            if (w1) m_ie = reg_wdata[0];
            if (wake) m_run = 1; else if (w2) m_run = reg_wdata[0];
            if (w2) m_go = reg_wdata[1];
            m_st = nst; m_dcnt = ndc;
        end
    end

    task automatic chk(input string tag, input int act, input int exp, input string what);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && run_chk && !done) begin
            #2;
            chk("R4", int'(irq), int'(m_evt & m_ie), "irq vs model");
            chk("R7", int'(susp_out), int'(m_st == S_SU), "susp_out vs model");
            chk("R9", int'(clk_en), int'(m_st != S_SU), "clk_en vs model");
            chk("R5", int'(reg_rdata), exp_rdata(int'(reg_addr)), "rdata vs model");
        end
    end

    task automatic report();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            nerr++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

    task automatic drive(input bit li, input bit wr, input int a, input int d);
        line_idle = li; reg_wr = wr; reg_addr = 2'(a); reg_wdata = 8'(d);
        @(negedge clk);
    endtask

    task automatic idle_cycles(input int n, input bit li);
        for (int i = 0; i < n; i++) drive(li, 1'b0, 0, 0);
    endtask

    task automatic peek(input int a, output int v);
        reg_wr = 1'b0; reg_addr = 2'(a); #1; v = int'(reg_rdata);
    endtask

    initial begin
        int v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        peek(0, v); chk("R11", v, 0, "status after reset");
        peek(1, v); chk("R11", v, 0, "enable after reset");
        peek(2, v); chk("R11", v, 1, "control after reset");
        chk("R11", int'(irq), 0, "irq after reset");
        chk("R11", int'(susp_out), 0, "susp_out after reset");
        chk("R11", int'(clk_en), 1, "clk_en after reset");
        run_chk = 1'b1;

        idle_cycles(2, 1'b0);
        idle_cycles(IDLE_T, 1'b1);
        peek(0, v); chk("R1", v, 0, "status at IDLE_CYC samples");
        idle_cycles(1, 1'b1);
        peek(0, v); chk("R1", v, 3, "status at IDLE_CYC+1 samples");

        drive(1, 1, 1, 1);
        chk("R4", int'(irq), 1, "irq with enable");
        drive(1, 1, 0, 0);
        peek(0, v); chk("R3", v & 1, 1, "event after write 0");
        peek(0, v); chk("R3", v & 1, 1, "event after second read");
        drive(1, 1, 0, 1);
        peek(0, v); chk("R3", v & 1, 0, "event after write 1");
        chk("R4", int'(irq), 0, "irq after clear");

        // R6 rejected handshake with clock-run left at 1
        drive(1, 1, 2, 3);
        drive(1, 1, 2, 1);
        idle_cycles(DLY_T + 2, 1'b1);
        chk("R6", int'(susp_out), 0, "no suspend with clock-run 1");

        // R5 and R7 accepted handshake
        drive(1, 1, 2, 2);
        peek(2, v); chk("R5", v, 2, "control go set run clear");
        drive(1, 1, 2, 0);
        idle_cycles(DLY_T - 1, 1'b1);
        chk("R7", int'(susp_out), 0, "susp_out one cycle early");
        idle_cycles(1, 1'b1);
        chk("R7", int'(susp_out), 1, "susp_out at delay end");
        chk("R7", int'(clk_en), 0, "clk_en at delay end");

        // R9 wake
        idle_cycles(1, 1'b0);
        chk("R9", int'(susp_out), 0, "susp_out after wake");
        chk("R9", int'(clk_en), 1, "clk_en after wake");
        peek(2, v); chk("R9", v & 1, 1, "clock-run after wake");
        peek(0, v); chk("R2", (v >> 1) & 1, 0, "bus bit after activity");

        // R8 cancel during delay
        idle_cycles(IDLE_T + 1, 1'b1);
        drive(1, 1, 0, 1);
        drive(1, 1, 2, 2);
        drive(1, 1, 2, 0);
        idle_cycles(3, 1'b1);
        idle_cycles(1, 1'b0);
        idle_cycles(DLY_T + 3, 1'b1);
        chk("R8", int'(susp_out), 0, "susp_out after cancel");

        // R12 abort in ARMED
        idle_cycles(1, 1'b0);
        idle_cycles(IDLE_T + 1, 1'b1);
        drive(1, 1, 2, 2);
        idle_cycles(1, 1'b0);
        peek(0, v); chk("R12", (v >> 1) & 1, 0, "bus bit after abort");
        drive(1, 1, 2, 0);
        idle_cycles(DLY_T + 2, 1'b1);
        chk("R12", int'(susp_out), 0, "susp_out after abort");

        // R10 handshake while awake
        idle_cycles(1, 1'b0);
        drive(1, 1, 2, 2);
        drive(1, 1, 2, 0);
        idle_cycles(DLY_T + 2, 1'b1);
        chk("R10", int'(susp_out), 0, "susp_out after awake handshake");

        // R3 detection collides with clearing write
        idle_cycles(1, 1'b0);
        drive(1, 1, 0, 1);
        idle_cycles(IDLE_T - 1, 1'b1);
        drive(1, 1, 0, 1);
        peek(0, v); chk("R3", v & 1, 1, "set wins over clear");
        drive(1, 1, 0, 1);
        peek(0, v); chk("R3", v & 1, 0, "clear after collision");

        // random phase, checked against the model every cycle
        for (int ep = 0; ep < 400; ep++) begin
            int len;
            if (ep % 2 == 1) begin
                idle_cycles(IDLE_T + 1 + $urandom_range(0, 3), 1'b1);
                drive(1, 1, 2, $urandom_range(2, 3));
                drive(1, 1, 2, ($urandom_range(0, 2) == 0) ? 1 : 0);
            end
            len = $urandom_range(1, IDLE_T + DLY_T + 12);
            for (int c = 0; c < len; c++) begin
                int a;
                bit wr;
                wr = ($urandom_range(0, 5) == 0);
                a = $urandom_range(0, 3);
                drive(1, wr, a, (a == 2) ? $urandom_range(0, 3) : $urandom_range(0, 255));
            end
            idle_cycles($urandom_range(1, 3), 1'b0);
        end
        idle_cycles(2, 1'b1);
        report();
    end
endmodule